// File: doc/BRIEF.md
# Set-associative instruction fetch cache

This block is a read-only instruction cache that sits between a processor fetch port and a 32-bit memory read port. Each fetch address is split into a block offset, a set index and a tag. The tag is compared against every way of the indexed set. A hit returns the stored word after a fixed hit latency and does not touch memory. A miss picks a victim way from a bank of per-line usage counters. It then refills the whole block from memory, one 32-bit word per read. The refill starts at the missed word and wraps around the block. The fetch is answered once the block is complete and a separate miss latency has elapsed.

A fetch goes straight to memory for a single word and leaves the cache contents alone in three cases: the cache is built as absent, the enable input is low, or the fetch carries a no-cache flag. A separate invalidate port removes lines by address. With the cache enabled it removes only the way whose tag matches. With the cache disabled it removes every way of the indexed set. An invalidate that arrives while a fetch is in flight is held and applied once the controller is idle again. If memory flags an error during a refill, the fetch returns zero and the victim line is left empty.

Top module: `ifetch_cache`

## Requirements
- R1: After reset, every line is invalid and every usage counter is 0. `req_ready` and `inv_ready` are 1, and `rsp_valid` and `mem_rd_valid` are 0. `mem_rd_valid` is never high while `req_ready` is high.
- R2: The set index is address bits [OFF+IDX-1:OFF], where OFF = log2(BLOCK_BYTES) and IDX = log2(SETS). The tag is address bits [ADDR_W-1:OFF+IDX]. Addresses with the same index and different tags compete for the ways of one set.
- R3: A fetch that hits returns the stored word with no memory read. `rsp_valid` rises 1+HIT_LAT clock edges after the accepting edge.
- R4: A miss reads the block as WPB = BLOCK_BYTES/4 word reads. The first read is the word holding the missed address, each later read is 4 bytes higher, and the offset wraps modulo BLOCK_BYTES. The response carries the missed word. When memory acknowledges every read in the cycle it is issued, `rsp_valid` rises 1+WPB+MISS_LAT edges after acceptance.
- R5: A fetch is a bypass when PRESENT is 0, `cache_en` is 0 or `req_nocache` is 1. A bypass makes one read at the word-aligned address and leaves tags, valid bits and counters unchanged. With an immediate acknowledge, `rsp_valid` rises 2 edges after acceptance.
- R6: A tag of all zeros is an ordinary valid tag. The block at address 0 caches and hits like any other block.
- R7: Each line has a usage counter from 0 to USTATES-1. The victim is the lowest-numbered way holding the smallest counter in the set. On a hit, the counters in that set that are above the hit way's counter drop by one, and the hit way is set to USTATES-1. On a miss, every nonzero counter in the set drops by one, and the victim is set to USTATES-1.
- R8: An invalidate with `cache_en`=1 clears the valid bit of the way whose tag matches and zeroes its counter. Other ways, and sets with no match, are untouched.
- R9: An invalidate with `cache_en`=0 clears every way of the indexed set and zeroes their counters, whatever the tag.
- R10: An invalidate accepted while the controller is not idle is held, and `inv_ready` stays 0 until it is applied. It is applied on the first idle cycle, before the next lookup.
- R11: A memory error during a refill answers the fetch on the next edge with data 0. The victim line is left invalid with counter 0. A bypass read with an error also returns 0.
- R12: While `mem_rd_valid` is high and `mem_rd_ack` is low, `mem_rd_valid` and `mem_rd_addr` hold their values.
- R13: `rsp_valid` is a single-cycle pulse for each accepted fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable; low makes fetches bypass and invalidates clear whole sets |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Controller idle and able to take a fetch |
| req_addr | input | ADDR_W | Fetch byte address |
| req_nocache | input | 1 | Read this fetch from memory without caching |
| rsp_valid | output | 1 | One-cycle pulse: fetch data valid |
| rsp_data | output | 32 | Fetched instruction word |
| mem_rd_valid | output | 1 | Memory word read request |
| mem_rd_addr | output | ADDR_W | Word-aligned memory read address |
| mem_rd_ack | input | 1 | Memory returns the word this cycle |
| mem_rd_data | input | 32 | Memory read data |
| mem_rd_err | input | 1 | Memory read failed (valid with ack) |
| inv_valid | input | 1 | Invalidate request |
| inv_ready | output | 1 | Invalidate can be accepted |
| inv_addr | input | ADDR_W | Address whose line is to be invalidated |

## Verification
The bench builds the cache with 4 sets, 2 ways, 16-byte blocks and two usage states. With these values a three-address sequence in one set exercises both victim choice and counter ageing, and whole-set clears are visible through later misses. The bench sets the hit latency to 2 and the miss latency to 3. Hits, misses and bypasses therefore take 3, 8 and 2 edges, so the response time alone tells the three paths apart. The memory model answers every read at once. In one test it withholds the acknowledge and in another it flags an error on one word, so the held address and the mid-refill error path are both reached.

// File: rtl/ifc_pkg.sv
// Shared types of the instruction fetch cache.
// Assumes: consumers import the package; encodings are internal only.
package ifc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WAIT,
        ST_FILL,
        ST_BYPASS,
        ST_DONE
    } ifc_state_e;

    typedef enum logic [1:0] {
        USE_NONE,
        USE_HIT,
        USE_FILL,
        USE_CLEAR
    } use_op_e;

endpackage

// File: rtl/ifc_tag_store.sv
// Tag and valid storage with a single compare port.
// Does: keeps one tag and one valid bit per line and compares the tag on the
// compare port against every way of one set.
// Assumes: SETS >= 2 and WAYS >= 2, both powers of two. Clear and write never
// target the same line in one cycle. Only the valid bits are reset.
module ifc_tag_store #(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] cmp_set,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic [WAYS-1:0]  hit_vec,
    input  logic             clr_en,
    input  logic [WAYS-1:0]  clr_mask,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    // Compare the tag against each way of the selected set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[cmp_set][w] && (tag_q[cmp_set][w] == cmp_tag);
    end

    // Valid bits: cleared on reset, by invalidates and at refill start, set on refill end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else begin
            if (clr_en) vld_q[cmp_set] <= vld_q[cmp_set] & ~clr_mask;
            if (wr_en)  vld_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag bits: written when a refill completes.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
    end

    // R3: no two valid ways of one set ever hold the same tag.
    assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/ifc_usage.sv
// Per-line usage counters and victim selection.
// Does: keeps a counter in 0..USTATES-1 for every line, ages them on hits and
// refills, and names the lowest-numbered way holding the smallest counter.
// Assumes: one operation per cycle. 2 <= USTATES <= 4.
module ifc_usage
    import ifc_pkg::*;
#(
    parameter int SETS    = 32,
    parameter int WAYS    = 4,
    parameter int USTATES = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(USTATES),
    localparam logic [CNT_W-1:0] TOP = CNT_W'(USTATES - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  use_op_e          op_i,
    input  logic [WAY_W-1:0] way_i,
    input  logic [WAYS-1:0]  clr_mask_i,
    output logic [WAY_W-1:0] victim_o
);

    logic [CNT_W-1:0] cnt_q [SETS][WAYS];

    // Pick the first way whose counter is the smallest of the set.
    always_comb begin
        logic [CNT_W-1:0] best;
        best     = TOP;
        victim_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cnt_q[set_i][w] < best) begin
                best     = cnt_q[set_i][w];
                victim_o = WAY_W'(w);
            end
        end
    end

    // Age, refresh or clear the counters of the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) cnt_q[s][w] <= '0;
        end else begin
            case (op_i)
                USE_HIT: begin
                    for (int w = 0; w < WAYS; w++)
                        if (cnt_q[set_i][w] > cnt_q[set_i][way_i])
                            cnt_q[set_i][w] <= cnt_q[set_i][w] - 1'b1;
                    cnt_q[set_i][way_i] <= TOP;
                end
                USE_FILL: begin
                    for (int w = 0; w < WAYS; w++)
                        if (cnt_q[set_i][w] != '0)
                            cnt_q[set_i][w] <= cnt_q[set_i][w] - 1'b1;
                    cnt_q[set_i][way_i] <= TOP;
                end
                USE_CLEAR: begin
                    for (int w = 0; w < WAYS; w++)
                        if (clr_mask_i[w]) cnt_q[set_i][w] <= '0;
                end
                default: ;
            endcase
        end
    end

    // R7: a touched way holds the top usage value on the following cycle.
    assert_touch_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == USE_HIT || op_i == USE_FILL) |=> cnt_q[$past(set_i)][$past(way_i)] == TOP);

    // R8: cleared ways read zero on the following cycle (first way shown).
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == USE_CLEAR && clr_mask_i[0]) |=> cnt_q[$past(set_i)][0] == '0);

endmodule

// File: rtl/ifetch_cache.sv
// Set-associative read-only instruction cache controller.
// Does: accepts fetches over a valid/ready handshake, looks the tag up one
// cycle later, answers hits after HIT_LAT cycles and refills misses
// starting at the missed word and wrapping around the block. It also
// handles bypass fetches and invalidates by address.
// Assumes: one outstanding memory read whose ack may come in the issue cycle.
// HIT_LAT and MISS_LAT are at least 1. SETS and WAYS are powers of two,
// each at least 2.
module ifetch_cache
    import ifc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 32,
    parameter int WAYS        = 4,
    parameter int BLOCK_BYTES = 16,
    parameter int USTATES     = 2,
    parameter int HIT_LAT     = 1,
    parameter int MISS_LAT    = 1,
    parameter bit PRESENT     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_nocache,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [31:0]       mem_rd_data,
    input  logic              mem_rd_err,
    input  logic              inv_valid,
    output logic              inv_ready,
    input  logic [ADDR_W-1:0] inv_addr
);

    localparam int WPB    = BLOCK_BYTES / 4;
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int WOFF_W = OFF_W - 2;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int LAT_MX = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
    localparam int LAT_W  = $clog2(LAT_MX + 1);

    ifc_state_e          state_q;
    logic [ADDR_W-1:2]   addr_q;
    logic                nocache_q;
    logic [WAY_W-1:0]    vic_q;
    logic [WOFF_W-1:0]   fcnt_q;
    logic [LAT_W-1:0]    lat_q;
    logic [31:0]         rdata_q;
    logic                inv_pend_q;
    logic [ADDR_W-1:OFF_W] inv_addr_q;
    logic [31:0]         data_q [SETS][WAYS][WPB];

    logic [SET_W-1:0]    idx_q;
    logic [TAG_W-1:0]    tag_a;
    logic [WOFF_W-1:0]   word_q;
    logic [WOFF_W-1:0]   fill_word;
    logic [ADDR_W-1:OFF_W] inv_eff;
    logic [SET_W-1:0]    cmp_set;
    logic [TAG_W-1:0]    cmp_tag;
    logic [WAYS-1:0]     hit_vec;
    logic                hit_any;
    logic [WAY_W-1:0]    hit_way;
    logic [WAY_W-1:0]    victim;
    logic                bypass;
    logic                inv_do;
    logic [WAYS-1:0]     inv_mask;
    use_op_e             use_op;
    logic [WAY_W-1:0]    use_way;
    logic [WAYS-1:0]     clr_mask;
    logic                clr_en;
    logic                fill_done;
    logic                mem_fire;

    assign idx_q     = addr_q[OFF_W+SET_W-1:OFF_W];
    assign tag_a     = addr_q[ADDR_W-1:OFF_W+SET_W];
    assign word_q    = addr_q[OFF_W-1:2];
    assign fill_word = word_q + fcnt_q;
    assign inv_eff   = inv_pend_q ? inv_addr_q : inv_addr[ADDR_W-1:OFF_W];
    assign cmp_set   = (state_q == ST_IDLE) ? inv_eff[OFF_W+SET_W-1:OFF_W] : idx_q;
    assign cmp_tag   = (state_q == ST_IDLE) ? inv_eff[ADDR_W-1:OFF_W+SET_W] : tag_a;
    assign hit_any   = |hit_vec;
    assign bypass    = !PRESENT || !cache_en || nocache_q;
    assign inv_do    = (state_q == ST_IDLE) && (inv_pend_q || inv_valid);
    assign inv_mask  = !PRESENT ? '0 : (cache_en ? hit_vec : '1);
    assign mem_fire  = mem_rd_valid && mem_rd_ack;
    assign fill_done = (state_q == ST_FILL) && mem_fire && !mem_rd_err
                       && (fcnt_q == WOFF_W'(WPB - 1));

    assign req_ready    = (state_q == ST_IDLE);
    assign inv_ready    = !inv_pend_q;
    assign rsp_valid    = (state_q == ST_DONE);
    assign rsp_data     = rdata_q;
    assign mem_rd_valid = (state_q == ST_FILL) || (state_q == ST_BYPASS);
    assign mem_rd_addr  = (state_q == ST_FILL)
                          ? {addr_q[ADDR_W-1:OFF_W], fill_word, 2'b00}
                          : {addr_q, 2'b00};

    // Encode the matching way as an index.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    // Choose the usage and valid-bit update for the current state.
    always_comb begin
        use_op   = USE_NONE;
        use_way  = hit_way;
        clr_mask = '0;
        clr_en   = 1'b0;
        case (state_q)
            ST_IDLE: if (inv_do) begin
                use_op   = USE_CLEAR;
                clr_mask = inv_mask;
                clr_en   = 1'b1;
            end
            ST_LOOKUP: if (!bypass) begin
                if (hit_any) begin
                    use_op = USE_HIT;
                end else begin
                    use_op   = USE_FILL;
                    use_way  = victim;
                    clr_mask = WAYS'(1) << victim;
                    clr_en   = 1'b1;
                end
            end
            ST_FILL: if (mem_fire && mem_rd_err) begin
                use_op   = USE_CLEAR;
                clr_mask = WAYS'(1) << vic_q;
            end
            default: ;
        endcase
    end

    ifc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_set  (cmp_set),
        .cmp_tag  (cmp_tag),
        .hit_vec  (hit_vec),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .wr_en    (fill_done),
        .wr_set   (idx_q),
        .wr_way   (vic_q),
        .wr_tag   (tag_a)
    );

    ifc_usage #(.SETS(SETS), .WAYS(WAYS), .USTATES(USTATES)) u_usage (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (cmp_set),
        .op_i       (use_op),
        .way_i      (use_way),
        .clr_mask_i (clr_mask),
        .victim_o   (victim)
    );

    // Hold one invalidate that arrives while the controller is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_pend_q <= 1'b0;
            inv_addr_q <= '0;
        end else if (state_q == ST_IDLE) begin
            inv_pend_q <= 1'b0;
        end else if (inv_valid && inv_ready) begin
            inv_pend_q <= 1'b1;
            inv_addr_q <= inv_addr[ADDR_W-1:OFF_W];
        end
    end

    // Store refill words into the victim line.
    always_ff @(posedge clk) begin
        if (state_q == ST_FILL && mem_fire && !mem_rd_err)
            data_q[idx_q][vic_q][fill_word] <= mem_rd_data;
    end

    // Fetch sequencing: lookup, latency wait, refill, bypass, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            nocache_q <= 1'b0;
            vic_q     <= '0;
            fcnt_q    <= '0;
            lat_q     <= '0;
            rdata_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q    <= req_addr[ADDR_W-1:2];
                    nocache_q <= req_nocache;
                    state_q   <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    if (bypass) begin
                        state_q <= ST_BYPASS;
                    end else if (hit_any) begin
                        rdata_q <= data_q[idx_q][hit_way][word_q];
                        lat_q   <= LAT_W'(HIT_LAT);
                        state_q <= ST_WAIT;
                    end else begin
                        vic_q   <= victim;
                        fcnt_q  <= '0;
                        state_q <= ST_FILL;
                    end
                end
                ST_WAIT: begin
                    if (lat_q <= LAT_W'(1)) state_q <= ST_DONE;
                    else                    lat_q   <= lat_q - 1'b1;
                end
                ST_FILL: if (mem_fire) begin
                    if (mem_rd_err) begin
                        rdata_q <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        if (fcnt_q == '0) rdata_q <= mem_rd_data;
                        if (fill_done) begin
                            lat_q   <= LAT_W'(MISS_LAT);
                            state_q <= ST_WAIT;
                        end
                        fcnt_q <= fcnt_q + 1'b1;
                    end
                end
                ST_BYPASS: if (mem_fire) begin
                    rdata_q <= mem_rd_err ? '0 : mem_rd_data;
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: no memory traffic while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid);

    // R4: consecutive refill reads step by one word, wrapping in the block.
    assert_fill_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_fire && !mem_rd_err && !fill_done)
        |=> mem_rd_addr[OFF_W-1:0] == OFF_W'($past(mem_rd_addr[OFF_W-1:0]) + OFF_W'(4)));

    // R10: a held invalidate stays held while the controller is busy.
    assert_inv_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_ready && !req_ready) |=> !inv_ready);

    // R11: a failed refill or bypass read answers next cycle with zero.
    assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fire && mem_rd_err) |=> (rsp_valid && rsp_data == 32'h0));

    // R12: a pending memory read keeps its address.
    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R13: a response lasts exactly one cycle.
    assert_rsp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_ifetch_cache.sv
// Self-checking bench: vector table first, then directed corner cases.
module tb_ifetch_cache;

    localparam int AW   = 32;
    localparam int HL   = 2;
    localparam int ML   = 3;
    localparam int WPB  = 4;
    localparam int N_HIT  = 1 + HL;
    localparam int N_MISS = 1 + WPB + ML;
    localparam int N_BYP  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cache_en = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic req_nocache = 1'b0;
    logic rsp_valid;
    logic [31:0] rsp_data;
    logic mem_rd_valid;
    logic [AW-1:0] mem_rd_addr;
    logic mem_rd_ack;
    logic [31:0] mem_rd_data;
    logic mem_rd_err;
    logic inv_valid = 1'b0;
    logic inv_ready;
    logic [AW-1:0] inv_addr = '0;

    logic ack_en = 1'b1;
    logic err_en = 1'b0;
    logic [AW-1:0] err_addr = '0;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    logic [AW-1:0] rd_log [16];

    always #10 clk = ~clk;

    function automatic logic [31:0] memword(input logic [AW-1:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1234_0000;
    endfunction

    assign mem_rd_ack  = mem_rd_valid && ack_en;
    assign mem_rd_data = memword(mem_rd_addr);
    assign mem_rd_err  = err_en && (mem_rd_addr == err_addr);

    ifetch_cache #(
        .ADDR_W(AW), .SETS(4), .WAYS(2), .BLOCK_BYTES(16),
        .USTATES(2), .HIT_LAT(HL), .MISS_LAT(ML), .PRESENT(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_nocache(req_nocache), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_rd_err(mem_rd_err), .inv_valid(inv_valid),
        .inv_ready(inv_ready), .inv_addr(inv_addr)
    );

    // Log every memory read that completes at the coming edge.
    always @(negedge clk) begin
        if (mem_rd_valid && mem_rd_ack) begin
            if (rd_cnt < 16) rd_log[rd_cnt] = mem_rd_addr;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue one fetch; return data, edges to response and reads made.
    task automatic do_fetch(input logic [AW-1:0] a, input logic nc,
                            output logic [31:0] d, output int n, output int r);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_cnt = 0;
        req_valid = 1'b1; req_addr = a; req_nocache = nc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        d = rsp_data;
        r = rd_cnt;
        @(negedge clk);
        chk("R13 rsp_valid low after pulse", 32'(rsp_valid), 32'h0);
    endtask

    // Fetch and check data, latency and read count for a kind: 0 hit, 1 miss, 2 bypass.
    task automatic fetch_exp(input logic [AW-1:0] a, input logic nc, input int kind, input string tag);
        logic [31:0] d;
        int n, r;
        int en, er;
        do_fetch(a, nc, d, n, r);
        en = (kind == 0) ? N_HIT : (kind == 1) ? N_MISS : N_BYP;
        er = (kind == 0) ? 0 : (kind == 1) ? WPB : 1;
        chk({tag, " data"}, d, memword({a[AW-1:2], 2'b00}));
        chk({tag, " edges"}, 32'(n), 32'(en));
        chk({tag, " reads"}, 32'(r), 32'(er));
    endtask

    task automatic do_inv(input logic [AW-1:0] a);
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
        @(negedge clk);
    endtask

    // Fields: [35:4] address, [3] no-cache, [2] enable, [1:0] kind.
    localparam logic [35:0] VEC [10] = '{
        {32'h0000_0008, 1'b0, 1'b1, 2'd1},   // R4 R6 miss, tag zero
        {32'h0000_0000, 1'b0, 1'b1, 2'd0},   // R6 hit on zero tag
        {32'h0000_000C, 1'b0, 1'b1, 2'd0},   // R3 hit other word
        {32'h0000_0104, 1'b0, 1'b1, 2'd1},   // R2 same set, new tag
        {32'h0000_0100, 1'b0, 1'b1, 2'd0},   // R3 hit second way
        {32'h0000_0014, 1'b0, 1'b1, 2'd1},   // R2 other set
        {32'h0000_0020, 1'b1, 1'b1, 2'd2},   // R5 no-cache bypass
        {32'h0000_0020, 1'b0, 1'b1, 2'd1},   // R5 bypass left no line
        {32'h0000_0044, 1'b0, 1'b0, 2'd2},   // R5 disabled bypass
        {32'h0000_0004, 1'b0, 1'b1, 2'd0}    // R5 earlier lines kept
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n, r;
        do_reset();
        // R1 reset state at the ports.
        chk("R1 req_ready", 32'(req_ready), 32'h1);
        chk("R1 inv_ready", 32'(inv_ready), 32'h1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R1 mem_rd_valid", 32'(mem_rd_valid), 32'h0);

        for (int i = 0; i < 10; i++) begin
            cache_en = VEC[i][2];
            fetch_exp(VEC[i][35:4], VEC[i][3], int'(VEC[i][1:0]), $sformatf("R3/R4/R5 vec%0d", i));
        end
        cache_en = 1'b1;

        // R1: reset empties the cache; R4 refill order wraps from the missed word.
        do_reset();
        fetch_exp(32'h0000_0238, 1'b0, 1, "R1 R4 miss after reset");
        chk("R4 order0", rd_log[0], 32'h0000_0238);
        chk("R4 order1", rd_log[1], 32'h0000_023C);
        chk("R4 order2", rd_log[2], 32'h0000_0230);
        chk("R4 order3", rd_log[3], 32'h0000_0234);

        // R7 R2 replacement in set 1 with A, B, C sharing the index.
        fetch_exp(32'h0000_0010, 1'b0, 1, "R7 A miss");
        fetch_exp(32'h0000_0050, 1'b0, 1, "R7 B miss");
        fetch_exp(32'h0000_0010, 1'b0, 0, "R7 A hit");
        fetch_exp(32'h0000_0090, 1'b0, 1, "R7 C evicts B");
        fetch_exp(32'h0000_0010, 1'b0, 0, "R7 A kept");
        fetch_exp(32'h0000_0050, 1'b0, 1, "R7 B was evicted");

        // R8: non-matching invalidate keeps both; matching one removes only A.
        do_inv(32'h0000_00D0);
        fetch_exp(32'h0000_0054, 1'b0, 0, "R8 B kept after miss-tag inv");
        fetch_exp(32'h0000_0014, 1'b0, 0, "R8 A kept after miss-tag inv");
        do_inv(32'h0000_001C);
        fetch_exp(32'h0000_0058, 1'b0, 0, "R8 B untouched");
        fetch_exp(32'h0000_0018, 1'b0, 1, "R8 A invalidated");

        // R9: disabled invalidate clears the whole set.
        cache_en = 1'b0;
        do_inv(32'h0000_00D0);
        cache_en = 1'b1;
        fetch_exp(32'h0000_0010, 1'b0, 1, "R9 A cleared");
        fetch_exp(32'h0000_0050, 1'b0, 1, "R9 B cleared");

        // R10: invalidate during a refill is held then applied.
        fork
            fetch_exp(32'h0000_00E0, 1'b0, 1, "R10 D miss");
            begin
                @(negedge clk);
                while (!mem_rd_valid) @(negedge clk);
                inv_valid = 1'b1; inv_addr = 32'h0000_00E4;
                @(negedge clk);
                inv_valid = 1'b0;
                chk("R10 inv_ready held low", 32'(inv_ready), 32'h0);
            end
        join
        @(negedge clk);
        chk("R10 inv_ready back", 32'(inv_ready), 32'h1);
        fetch_exp(32'h0000_00E0, 1'b0, 1, "R10 D invalidated");

        // R11: error on the third refill word returns zero, line stays empty.
        err_en = 1'b1; err_addr = 32'h0000_0148;
        do_fetch(32'h0000_0140, 1'b0, d, n, r);
        chk("R11 data zero", d, 32'h0);
        chk("R11 edges", 32'(n), 32'd4);
        chk("R11 reads", 32'(r), 32'd3);
        err_en = 1'b0;
        fetch_exp(32'h0000_0140, 1'b0, 1, "R11 line left invalid");

        // R12: withheld acknowledge keeps the bypass read steady.
        ack_en = 1'b0;
        fork
            do_fetch(32'h0000_0300, 1'b1, d, n, r);
            begin
                logic [AW-1:0] held;
                @(negedge clk);
                while (!mem_rd_valid) @(negedge clk);
                held = mem_rd_addr;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    chk("R12 valid held", 32'(mem_rd_valid), 32'h1);
                    chk("R12 addr held", mem_rd_addr, held);
                end
                ack_en = 1'b1;
            end
        join
        chk("R12 data", d, memword(32'h0000_0300));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule